// File: doc/BRIEF.md
# Banked Interrupt Mask Priority Unit

This block holds the interrupt-masking state of a small processor core that runs in one of two security states, secure or non-secure. Each state has its own one-bit priority mask and its own 8-bit base priority. A single fault mask is shared by both states. Register reads and writes go through a 5-bit register number, and the current security-state bit always picks which banked copy is accessed.

From the copies of the current state, plus the shared fault mask and a 3-bit binary-point value, the block computes the current execution priority each cycle. The result is a registered, signed 9-bit value that interrupt arbitration logic compares against pending priorities. A lower value means a stronger boost, and the value 255 means that no mask is in force.

Top module: `bmask_unit`

## Requirements
- R1: On synchronous active-high reset, both priority-mask copies, both base-priority copies and the fault mask read as zero, `exec_prio` is 255 and `exec_prio_vld` is low. `exec_prio_vld` goes high after the first clock edge with reset low and then stays high.
- R2: A write to register number 16 stores `wr_data[0]` into the priority-mask copy selected by `sec_state` (1 = secure, 0 = non-secure). The other copy is left unchanged.
- R3: A write to register number 17 stores `wr_data[7:0]` into the base-priority copy of the current state. The other copy is left unchanged.
- R4: Reads of numbers 16 and 17 return the current state's copy, zero-extended. Number 18 reads the same value as 17.
- R5: A write to number 18 updates the current base-priority copy only if the new value is nonzero and the stored value is zero or larger than the new value. Otherwise the write is dropped.
- R6: Number 19 is the shared fault mask. A write stores `wr_data[0]`, and the read returns that bit in either security state.
- R7: Any register number other than 16 to 19 reads as zero, and writes to it change no state.
- R8: While the fault mask is set, the execution priority is -1 (9'h1FF).
- R9: While the fault mask is clear and the current priority-mask copy is set, the execution priority is 0.
- R10: Otherwise, when the current base priority `bp` is nonzero, the execution priority is `bp & (8'hFF << (bin_point+1))`. A binary point of 7 gives 0. When `bp` is zero, the execution priority is 255.
- R11: `exec_prio` is registered. It reflects a register write one clock edge after the write is taken, and it reflects a change of `sec_state` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_state | input | 1 | Current security state, 1 = secure |
| reg_sel | input | 5 | Register number for the read and write access |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read of the selected register |
| bin_point | input | 3 | Binary point that sets the group-priority mask |
| exec_prio | output | 9 | Registered signed execution priority |
| exec_prio_vld | output | 1 | Execution priority valid after reset |

## Verification
The assertions assume that `sec_state`, `reg_sel`, `wr_en` and `bin_point` are driven to known values at every clock edge once reset is released. They also assume that a write strobe targets one register number for exactly one cycle. The bench changes all inputs only on the falling edge and drops `wr_en` after a single cycle. It switches the security state between accesses, never while a write is being taken. Because of this, each banked copy is touched only when the test means to touch it.

// File: rtl/bmask_pkg.sv
package bmask_pkg;

    localparam int PRIO_W = 8;
    localparam int BPT_W  = 3;
    localparam int SEL_W  = 5;
    localparam int DATA_W = 32;
    localparam int EXEC_W = PRIO_W + 1;
    localparam int NBANK  = 2;

    localparam logic signed [EXEC_W-1:0] PRIO_FAULT   = -9'sd1;
    localparam logic signed [EXEC_W-1:0] PRIO_MASKED  = 9'sd0;
    localparam logic signed [EXEC_W-1:0] PRIO_NOBOOST = 9'sd255;

    typedef enum logic [SEL_W-1:0] {
        SEL_PMASK = 5'd16,
        SEL_BPRI  = 5'd17,
        SEL_BPMAX = 5'd18,
        SEL_FMASK = 5'd19
    } sel_e;

    typedef struct packed {
        logic [NBANK-1:0]             pmask;
        logic [NBANK-1:0][PRIO_W-1:0] bpri;
        logic                         fmask;
    } mask_state_t;

    function automatic logic [PRIO_W-1:0] group_mask(input logic [BPT_W-1:0] bpt);
        logic [BPT_W:0] sh;
        sh = {1'b0, bpt} + 1'b1;
        return {PRIO_W{1'b1}} << sh;
    endfunction

    function automatic logic bpmax_take(input logic [PRIO_W-1:0] cur,
                                        input logic [PRIO_W-1:0] nxt);
        return (nxt != '0) && ((cur == '0) || (nxt < cur));
    endfunction

endpackage

// File: rtl/bmask_bank.sv
module bmask_bank
    import bmask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [PRIO_W-1:0] wdata_i,
    output mask_state_t       state_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [NBANK-1:0]             pm_q;
    logic [NBANK-1:0][PRIO_W-1:0] bp_q;
    logic                         fm_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic BSEL = 1'(b);
        logic hit;
        assign hit = wr_en_i && (sec_i == BSEL);

        always_ff @(posedge clk) begin
            if (rst) begin
                pm_q[b] <= 1'b0;
                bp_q[b] <= '0;
            end else if (hit) begin
                if (sel_i == SEL_PMASK)
                    pm_q[b] <= wdata_i[0];
                if (sel_i == SEL_BPRI)
                    bp_q[b] <= wdata_i;
                if (sel_i == SEL_BPMAX && bpmax_take(bp_q[b], wdata_i))
                    bp_q[b] <= wdata_i;
            end
        end

        AST_BANK_ISOLATE: assert property (@(posedge clk) disable iff (rst)
            (wr_en_i && sec_i != BSEL) |=> ($stable(pm_q[b]) && $stable(bp_q[b]))); // R2

        AST_BPMAX_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
            (wr_en_i && sel_i == SEL_BPMAX && sec_i == BSEL && bp_q[b] != '0)
            |=> (bp_q[b] <= $past(bp_q[b]))); // R5
    end

    always_ff @(posedge clk) begin
        if (rst)
            fm_q <= 1'b0;
        else if (wr_en_i && sel_i == SEL_FMASK)
            fm_q <= wdata_i[0];
    end

    always_comb begin
        rdata_o = '0;
        case (sel_i)
            SEL_PMASK:            rdata_o[0]          = pm_q[sec_i];
            SEL_BPRI, SEL_BPMAX:  rdata_o[PRIO_W-1:0] = bp_q[sec_i];
            SEL_FMASK:            rdata_o[0]          = fm_q;
            default:              rdata_o             = '0;
        endcase
    end

    assign state_o.pmask = pm_q;
    assign state_o.bpri  = bp_q;
    assign state_o.fmask = fm_q;

    AST_FMASK_SHARED: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && sel_i != SEL_FMASK) |=> $stable(fm_q)); // R6

endmodule

// File: rtl/bmask_prio.sv
module bmask_prio
    import bmask_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fm_i,
    input  logic                     pm_i,
    input  logic [PRIO_W-1:0]        bp_i,
    input  logic [BPT_W-1:0]         bpt_i,
    output logic signed [EXEC_W-1:0] prio_o,
    output logic                     vld_o
);

    logic signed [EXEC_W-1:0] prio_d;

    always_comb begin
        if (fm_i)
            prio_d = PRIO_FAULT;
        else if (pm_i)
            prio_d = PRIO_MASKED;
        else if (bp_i != '0)
            prio_d = $signed({1'b0, bp_i & group_mask(bpt_i)});
        else
            prio_d = PRIO_NOBOOST;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_o <= PRIO_NOBOOST;
            vld_o  <= 1'b0;
        end else begin
            prio_o <= prio_d;
            vld_o  <= 1'b1;
        end
    end

    AST_FAULT_TOP: assert property (@(posedge clk) disable iff (rst)
        fm_i |=> (prio_o == PRIO_FAULT)); // R8

    AST_PMASK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!fm_i && pm_i) |=> (prio_o == PRIO_MASKED)); // R9

    AST_BPRI_BOUND: assert property (@(posedge clk) disable iff (rst)
        (!fm_i && !pm_i && bp_i != '0)
        |=> (prio_o >= 0 && prio_o <= $signed({1'b0, $past(bp_i)}))); // R10

    AST_NOBOOST: assert property (@(posedge clk) disable iff (rst)
        (!fm_i && !pm_i && bp_i == '0) |=> (prio_o == PRIO_NOBOOST)); // R10

    AST_VLD_HOLD: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> vld_o); // R1

endmodule

// File: rtl/bmask_unit.sv
module bmask_unit
    import bmask_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sec_state,
    input  logic [SEL_W-1:0]         reg_sel,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data,
    input  logic [BPT_W-1:0]         bin_point,
    output logic signed [EXEC_W-1:0] exec_prio,
    output logic                     exec_prio_vld
);

    mask_state_t st;
    logic        unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DATA_W-1:PRIO_W];

    bmask_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .sec_i   (sec_state),
        .wr_en_i (wr_en),
        .sel_i   (reg_sel),
        .wdata_i (wr_data[PRIO_W-1:0]),
        .state_o (st),
        .rdata_o (rd_data)
    );

    bmask_prio u_prio (
        .clk    (clk),
        .rst    (rst),
        .fm_i   (st.fmask),
        .pm_i   (st.pmask[sec_state]),
        .bp_i   (st.bpri[sec_state]),
        .bpt_i  (bin_point),
        .prio_o (exec_prio),
        .vld_o  (exec_prio_vld)
    );

endmodule

// File: tb/tb_bmask_unit.sv
`timescale 1ns/1ps
module tb_bmask_unit;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sec_state = 1'b0;
    logic [4:0]         reg_sel = '0;
    logic               wr_en = 1'b0;
    logic [31:0]        wr_data = '0;
    logic [31:0]        rd_data;
    logic [2:0]         bin_point = '0;
    logic signed [8:0]  exec_prio;
    logic               exec_prio_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bmask_unit dut (
        .clk(clk), .rst(rst), .sec_state(sec_state), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .bin_point(bin_point), .exec_prio(exec_prio), .exec_prio_vld(exec_prio_vld)
    );

    // {req[3:0], we, sec, sel[4:0], data[8:0], bpt[2:0], exp_rd[7:0], exp_prio[8:0]}
    localparam int NV = 18;
    localparam logic [39:0] VEC [NV] = '{
        {4'd2,  1'b1, 1'b0, 5'd16, 9'h001, 3'd0, 8'h01, 9'h000}, // R2 R9 ns mask set
        {4'd2,  1'b0, 1'b1, 5'd16, 9'h000, 3'd0, 8'h00, 9'h0FF}, // R2 secure copy clear
        {4'd3,  1'b1, 1'b1, 5'd17, 9'h045, 3'd0, 8'h45, 9'h044}, // R3 R10
        {4'd4,  1'b0, 1'b1, 5'd18, 9'h000, 3'd2, 8'h45, 9'h040}, // R4 alias, R10 bp=2
        {4'd3,  1'b0, 1'b0, 5'd17, 9'h000, 3'd2, 8'h00, 9'h000}, // R3 ns bp untouched
        {4'd2,  1'b1, 1'b0, 5'd16, 9'h0FE, 3'd2, 8'h00, 9'h0FF}, // R2 bit0 only
        {4'd5,  1'b1, 1'b1, 5'd18, 9'h060, 3'd0, 8'h45, 9'h044}, // R5 higher dropped
        {4'd5,  1'b1, 1'b1, 5'd18, 9'h030, 3'd0, 8'h30, 9'h030}, // R5 lower taken
        {4'd5,  1'b1, 1'b1, 5'd18, 9'h000, 3'd0, 8'h30, 9'h030}, // R5 zero dropped
        {4'd5,  1'b1, 1'b0, 5'd18, 9'h080, 3'd0, 8'h80, 9'h080}, // R5 from zero
        {4'd8,  1'b1, 1'b1, 5'd19, 9'h003, 3'd0, 8'h01, 9'h1FF}, // R6 R8
        {4'd6,  1'b0, 1'b0, 5'd19, 9'h000, 3'd0, 8'h01, 9'h1FF}, // R6 shared
        {4'd7,  1'b1, 1'b0, 5'd20, 9'h0FF, 3'd0, 8'h00, 9'h1FF}, // R7
        {4'd6,  1'b1, 1'b0, 5'd19, 9'h000, 3'd0, 8'h00, 9'h080}, // R6 clear
        {4'd7,  1'b1, 1'b0, 5'd15, 9'h001, 3'd0, 8'h00, 9'h080}, // R7 no effect
        {4'd10, 1'b0, 1'b0, 5'd17, 9'h000, 3'd7, 8'h80, 9'h000}, // R10 bp=7
        {4'd3,  1'b1, 1'b1, 5'd17, 9'h1A3, 3'd0, 8'hA3, 9'h0A2}, // R3 bits 7:0
        {4'd3,  1'b0, 1'b0, 5'd16, 9'h000, 3'd0, 8'h00, 9'h080}  // R3 ns intact
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 vld in reset", 32'(exec_prio_vld), 32'd0);
        chk("R1 prio in reset", 32'(exec_prio), 32'h0FF);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 vld after reset", 32'(exec_prio_vld), 32'd1);
        chk("R1 prio after reset", 32'(exec_prio), 32'h0FF);

        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            string tg;
            v = VEC[i];
            tg = $sformatf("R%0d vec%0d", v[39:36], i);
            wr_en     = v[35];
            sec_state = v[34];
            reg_sel   = v[33:29];
            wr_data   = {23'd0, v[28:20]};
            bin_point = v[19:17];
            @(negedge clk);
            wr_en = 1'b0;
            @(negedge clk);
            chk({tg, " rd"}, rd_data, {24'd0, v[16:9]});
            chk({tg, " prio"}, 32'(v[8:0]), 32'(exec_prio[8:0]));
        end

        // R11 write timing: ns state, prio 0x80, set ns mask
        sec_state = 1'b0; bin_point = 3'd0;
        reg_sel = 5'd16; wr_data = 32'd1; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 prio one edge after write", 32'(exec_prio[8:0]), 32'h080);
        @(negedge clk);
        chk("R11 prio two edges after write", 32'(exec_prio[8:0]), 32'h000);

        // R11 security switch timing
        sec_state = 1'b1;
        #1;
        chk("R11 prio before edge", 32'(exec_prio[8:0]), 32'h000);
        @(negedge clk);
        chk("R11 prio after sec switch", 32'(exec_prio[8:0]), 32'h0A2);

        // R1 second reset clears everything
        rst = 1'b1;
        @(negedge clk);
        chk("R1 vld low", 32'(exec_prio_vld), 32'd0);
        chk("R1 prio reset", 32'(exec_prio[8:0]), 32'h0FF);
        for (int s = 0; s < 2; s++) begin
            for (int r = 16; r < 20; r++) begin
                sec_state = 1'(s);
                reg_sel = 5'(r);
                #1;
                chk($sformatf("R1 reg%0d sec%0d zero", r, s), rd_data, 32'd0);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 vld rises", 32'(exec_prio_vld), 32'd1);

        finish_run();
    end

endmodule